// File: doc/BRIEF.md
# Coin Accumulating Vending Controller

This block is a clocked controller that keeps a running credit toward one fixed item price of 30 cents. A coin sensor upstream classifies each inserted coin and presents at most one event per clock: a strobe plus a two-bit code that identifies a nickel, a dime, a quarter or a rejected object. The controller adds the value of each accepted coin to its credit. When a coin brings the credit to the price or past it, the controller emits a one-cycle sale pulse and drops the credit back to zero.

No change is ever returned. If a coin pushes the total past the price, for example a second quarter after the first, the sale still happens and the excess is lost. A rejected object adds nothing and produces a one-cycle reject pulse. Credit is held internally in units of 5 cents, so only the states 0, 5, 10, 15, 20 and 25 cents exist. A credit code outside that range is treated as corrupt and falls back to zero on the next clock.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the credit becomes 0 and `sell` and `reject` are 0 after that edge. The reset is synchronous and active low.
- R2: With `coin_vld` high, coin code 2'b00 adds 5 cents, 2'b01 adds 10 cents and 2'b10 adds 25 cents to the credit.
- R3: `sell` goes high for exactly one cycle, in the cycle after the edge that accepts a coin bringing the credit to 30 cents or more. At no other time is it high.
- R4: In the same cycle that `sell` is high, the credit is 0. Any amount above 30 cents is forfeited, so 25+25 cents sells once, and the next sale again needs a full 30 cents.
- R5: With `coin_vld` high and code 2'b11, `reject` is high for one cycle after that edge, the credit is unchanged and `sell` stays low.
- R6: With `coin_vld` low, the credit holds and `sell` and `reject` stay low in the next cycle.
- R7: `sell` and `reject` are never high in the same cycle.
- R8: The stored credit is always below the price. An out-of-range credit code returns to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| coin_vld | input | 1 | One-cycle strobe: a classified coin event is present |
| coin_code | input | 2 | Coin class: 00 nickel, 01 dime, 10 quarter, 11 reject |
| sell | output | 1 | One-cycle sale pulse |
| reject | output | 1 | One-cycle rejected-coin pulse |

## Verification
The bench builds the block with its default parameters: a price of 6 units of 5 cents and coin weights of 1, 2 and 5 units. With these values every credit state from 0 to 25 cents is reachable. Exact hits on the price and overshoots of 5 to 20 cents can both occur, and the three-bit credit register has two unused codes that the recovery logic has to cover. Random coin streams with occasional resets sweep all the credit and coin combinations, and directed sequences pin down the exact sale, the overshoot sale and the reject and idle cases.

// File: rtl/vend_pkg.sv
// Package: shared coin codes for the vending controller.
// Assumes the coin sensor presents exactly these four classes.
package vend_pkg;
    typedef enum logic [1:0] {
        COIN_NICKEL  = 2'b00,
        COIN_DIME    = 2'b01,
        COIN_QUARTER = 2'b10,
        COIN_BAD     = 2'b11
    } coin_e;
endpackage

// File: rtl/vend_coin_decode.sv
// Module: vend_coin_decode
// Turns a classified coin event into a credit increment in 5-cent units
// and an accept/reject decision. Purely combinational; assumes at most
// one event per clock.
module vend_coin_decode
    import vend_pkg::*;
#(
    parameter int NICKEL_UNITS  = 1,
    parameter int DIME_UNITS    = 2,
    parameter int QUARTER_UNITS = 5,
    parameter int UNIT_W        = 3
) (
    input  logic              coin_vld,
    input  logic [1:0]        coin_code,
    output logic [UNIT_W-1:0] add_units,
    output logic              accept,
    output logic              refuse
);
    // Map the coin class to its value and to the accept/reject flags.
    always_comb begin
        add_units = '0;
        accept    = 1'b0;
        refuse    = 1'b0;
        if (coin_vld) begin
            unique case (coin_e'(coin_code))
                COIN_NICKEL:  begin add_units = UNIT_W'(NICKEL_UNITS);  accept = 1'b1; end
                COIN_DIME:    begin add_units = UNIT_W'(DIME_UNITS);    accept = 1'b1; end
                COIN_QUARTER: begin add_units = UNIT_W'(QUARTER_UNITS); accept = 1'b1; end
                default:      refuse = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/vend_credit_fsm.sv
// Module: vend_credit_fsm
// Holds the credit state (0 .. PRICE_UNITS-1 units of 5 cents) and detects
// a sale on the transition. An out-of-range state code is treated as
// corrupt and returns to zero. Assumes add_units is zero unless accept is set.
module vend_credit_fsm #(
    parameter int PRICE_UNITS = 6,
    parameter int UNIT_W      = 3,
    parameter int CREDIT_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [UNIT_W-1:0]   add_units,
    output logic [CREDIT_W-1:0] credit,
    output logic                sale_hit
);
    localparam int SUM_W = (CREDIT_W > UNIT_W ? CREDIT_W : UNIT_W) + 1;

    logic [CREDIT_W-1:0] credit_q, credit_d;
    logic [SUM_W-1:0]    sum;
    logic                state_bad;

    // Flag credit codes that no legal transition can produce.
    assign state_bad = (SUM_W'(credit_q) >= SUM_W'(PRICE_UNITS));
    assign sum       = SUM_W'(credit_q) + SUM_W'(add_units);

    // Next-credit and sale decision.
    always_comb begin
        sale_hit = 1'b0;
        credit_d = credit_q;
        if (state_bad) begin
            credit_d = '0;
        end else if (accept) begin
            if (sum >= SUM_W'(PRICE_UNITS)) begin
                sale_hit = 1'b1;
                credit_d = '0;
            end else begin
                credit_d = CREDIT_W'(sum);
            end
        end
    end

    // Credit register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) credit_q <= '0;
        else        credit_q <= credit_d;
    end

    assign credit = credit_q;
endmodule

// File: rtl/vend_ctrl.sv
// Module: vend_ctrl (top)
// Coin-accumulating vending controller for a single fixed price. Decodes
// coin events, accumulates credit, and emits registered one-cycle sell and
// reject pulses. Overpayment is forfeited. Assumes one coin event per clock.
module vend_ctrl #(
    parameter int PRICE_UNITS   = 6,
    parameter int NICKEL_UNITS  = 1,
    parameter int DIME_UNITS    = 2,
    parameter int QUARTER_UNITS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       coin_vld,
    input  logic [1:0] coin_code,
    output logic       sell,
    output logic       reject
);
    localparam int CREDIT_W = (PRICE_UNITS > 2) ? $clog2(PRICE_UNITS) : 1;
    localparam int UNIT_W   = $clog2(QUARTER_UNITS + 1) + 1;

    logic [UNIT_W-1:0]   add_units;
    logic                accept, refuse, sale_hit;
    logic [CREDIT_W-1:0] credit_q;

    vend_coin_decode #(
        .NICKEL_UNITS (NICKEL_UNITS),
        .DIME_UNITS   (DIME_UNITS),
        .QUARTER_UNITS(QUARTER_UNITS),
        .UNIT_W       (UNIT_W)
    ) u_decode (
        .coin_vld (coin_vld),
        .coin_code(coin_code),
        .add_units(add_units),
        .accept   (accept),
        .refuse   (refuse)
    );

    vend_credit_fsm #(
        .PRICE_UNITS(PRICE_UNITS),
        .UNIT_W     (UNIT_W),
        .CREDIT_W   (CREDIT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .add_units(add_units),
        .credit   (credit_q),
        .sale_hit (sale_hit)
    );

    // Register the sale and reject pulses for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sell   <= 1'b0;
            reject <= 1'b0;
        end else begin
            sell   <= sale_hit;
            reject <= refuse;
        end
    end
endmodule

// File: rtl/vend_ctrl_chk.sv
// Module: vend_ctrl_chk
// Property checker for vend_ctrl, attached by bind. Observes ports and the
// credit register; drives nothing.
module vend_ctrl_chk #(
    parameter int PRICE_UNITS = 6,
    parameter int CREDIT_W    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                coin_vld,
    input logic [1:0]          coin_code,
    input logic                sell,
    input logic                reject,
    input logic [CREDIT_W-1:0] credit
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (credit == '0 && !sell && !reject));

    // R2
    nickel_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coin_vld && coin_code == 2'b00 && 32'(credit) < PRICE_UNITS - 1)
        |=> (32'(credit) == 32'($past(credit)) + 1));

    // R3
    sell_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sell |=> !sell);

    // R4
    sell_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sell |-> credit == '0);

    // R5
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coin_vld && coin_code == 2'b11) |=> (reject && !sell && $stable(credit)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !coin_vld |=> (!sell && !reject && $stable(credit)));

    // R7
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sell && reject));

    // R8
    credit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(credit) < PRICE_UNITS);
endmodule

bind vend_ctrl vend_ctrl_chk #(
    .PRICE_UNITS(PRICE_UNITS),
    .CREDIT_W   (CREDIT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .coin_vld (coin_vld),
    .coin_code(coin_code),
    .sell     (sell),
    .reject   (reject),
    .credit   (credit_q)
);

// File: tb/vend_ctrl_test.sv
`timescale 1ns/1ps
// Bench for vend_ctrl: directed corner cases plus seeded random coin streams,
// checked cycle by cycle against a reference credit model.
module vend_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       coin_vld = 1'b0;
    logic [1:0] coin_code = 2'b00;
    logic       sell, reject;

    int checks = 0;
    int fails  = 0;
    int model_credit = 0;   // cents
    bit exp_sell = 0, exp_rej = 0;
    bit finished = 0;

    vend_ctrl uut (
        .clk(clk), .rst_n(rst_n), .coin_vld(coin_vld),
        .coin_code(coin_code), .sell(sell), .reject(reject)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Coin value in cents from the requirement encoding (R2); -1 = reject.
    function automatic int coin_cents(input logic [1:0] c);
        case (c)
            2'b00:   return 5;
            2'b01:   return 10;
            2'b10:   return 25;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: drive at the negedge, update the model at the edge,
    // compare outputs at the next negedge.
    task automatic cycle(input bit rst, input bit vld, input logic [1:0] code, input string req);
        rst_n     = !rst;
        coin_vld  = vld;
        coin_code = code;
        @(posedge clk);
        if (rst) begin
            model_credit = 0; exp_sell = 0; exp_rej = 0;
        end else begin
            exp_sell = 0; exp_rej = 0;
            if (vld) begin
                if (coin_cents(code) < 0) exp_rej = 1;
                else if (model_credit + coin_cents(code) >= 30) begin
                    exp_sell = 1; model_credit = 0;
                end else model_credit += coin_cents(code);
            end
        end
        @(negedge clk);
        chk(req, "sell", int'(sell), int'(exp_sell));
        chk(req, "reject", int'(reject), int'(exp_rej));
        chk("R7", "sell&reject", int'(sell && reject), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        @(negedge clk);
        // R1: reset state, including coins offered during reset.
        cycle(1, 0, 2'b00, "R1");
        cycle(1, 1, 2'b10, "R1");
        cycle(1, 1, 2'b11, "R1");
        // R2/R3: six nickels, sale on the sixth.
        for (int i = 0; i < 6; i++) cycle(0, 1, 2'b00, "R2");
        cycle(0, 0, 2'b00, "R3");
        // R2: three dimes.
        for (int i = 0; i < 3; i++) cycle(0, 1, 2'b01, "R2");
        // R4: two quarters overshoot, excess forfeited; then 30 cents needed again.
        cycle(0, 1, 2'b10, "R4");
        cycle(0, 1, 2'b10, "R4");
        for (int i = 0; i < 5; i++) cycle(0, 1, 2'b00, "R4");
        cycle(0, 1, 2'b00, "R4");
        // R8: 25 cents then a dime sells rather than holding 35.
        for (int i = 0; i < 5; i++) cycle(0, 1, 2'b00, "R8");
        cycle(0, 1, 2'b01, "R8");
        // R5: reject mid-accumulation leaves credit; quarter+nickel then sells.
        cycle(0, 1, 2'b10, "R5");
        cycle(0, 1, 2'b11, "R5");
        cycle(0, 1, 2'b11, "R5");
        cycle(0, 1, 2'b00, "R5");
        // R6: idle cycles hold 20 cents; a dime then sells exactly.
        cycle(0, 1, 2'b01, "R6");
        cycle(0, 1, 2'b01, "R6");
        for (int i = 0; i < 4; i++) cycle(0, 0, 2'b01, "R6");
        cycle(0, 1, 2'b01, "R6");
        // R1: reset mid-credit discards it.
        cycle(0, 1, 2'b10, "R1");
        cycle(1, 0, 2'b00, "R1");
        cycle(0, 1, 2'b00, "R1");
        cycle(0, 1, 2'b10, "R1");
        // Random stream with occasional resets.
        for (int i = 0; i < 4000; i++) begin
            bit r = ($urandom % 200) == 0;
            bit v = ($urandom % 10) < 6;
            logic [1:0] c = 2'($urandom % 4);
            string t;
            if (r) t = "R1";
            else if (!v) t = "R6";
            else if (c == 2'b11) t = "R5";
            else t = "R3";
            cycle(r, v, c, t);
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule